// File: doc/BRIEF.md
# Flash Completion Status Poller

This block decides when an embedded flash program or erase operation has finished and how it ended. After the command sequence has been issued elsewhere, a single `start_i` pulse hands the poller a per-operation iteration budget. The poller first follows the device's ready/busy line. It waits for the line to drop, and then for it to rise again. Each of these two waits is limited by the budget, which is reloaded for the second wait. The ready/busy line is asynchronous and passes through a two-flop synchronizer before the poller uses it.

The poller then runs the toggle-bit loop. Each pass uses up one unit of the budget and fetches two status words through a simple word-read port. While the device is busy it flips bit 6 on every status read. Equal bit 6 in a pair therefore means the operation is complete. When the first pair still toggles, a second confirming pair is fetched. If that pair also toggles and bit 5 (the device's internal time-limit flag) was set in its first word, the operation has failed. An empty budget ends the operation as a timeout.

The outcome appears on a registered two-bit code with a one-cycle done strobe. The code is held until the next outcome. Budgets span from a few thousand passes for a word program to several hundred million for a full-array erase, so the budget counter is at least 30 bits wide.

Top module: `nor_status_poller`

## Requirements
- R1: While reset is asserted and after its release, `done_o` and `rd_req_o` are low and `result_o` is 2'b00 (no result).
- R2: After an accepted start, no status read is requested while the synchronized ready/busy line stays high, until that first wait has used up `limit_i` cycles.
- R3: The second wait follows. It reloads the budget from the captured limit, and no read is requested while the synchronized line stays low until that reloaded budget runs out.
- R4: Each polling pass decrements the budget and reads two status words. If bit 6 is equal in both, the result is success, code 2'b01, after two reads in that pass.
- R5: If bit 6 differs in the first pair, a second pair is read, and equal bit 6 in it gives success (2'b01). This holds even when this pass used the last unit of the budget.
- R6: If bit 6 also differs in the second pair and bit 5 of the third word of the pass is 1, the result is error, code 2'b10.
- R7: When a pass is about to begin with zero budget left, the result is timeout, code 2'b11. A limit of zero gives a timeout with no reads at all.
- R8: `rd_req_o` stays high until `rd_ack_i` is seen. Exactly one word is consumed per cycle in which both are high, and the number of words consumed equals the number the algorithm calls for.
- R9: `done_o` is high for exactly one cycle per operation, and `result_o` keeps its value until the next done.
- R10: A `start_i` pulse arriving while an operation is in progress is ignored: it produces no extra done and does not change the outcome.
- R11: The budget counter takes a full `CNT_W`-bit limit (default 32) without truncation. A limit of 0x4000_0000 behaves as a non-zero budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin polling, accepted only when idle |
| limit_i | input | CNT_W | Budget for each wait phase and for the polling passes |
| rdy_busy_i | input | 1 | Asynchronous device ready/busy line (high = ready) |
| rd_req_o | output | 1 | Status word read request |
| rd_ack_i | input | 1 | Read acknowledge, `rd_data_i` valid in the same cycle |
| rd_data_i | input | DATA_W | Status word returned by the read port |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 2 | 01 success, 10 error, 11 timeout, 00 none yet |

## Verification
A pass can use the last unit of the budget and still find completion in its reads, so budget exhaustion and a success decision fall in the same pass. The bench provokes this with a limit of one and a device whose bit 6 stops toggling only at the third read. It judges the result as success after exactly four reads rather than a timeout. Random ack stalls make the compare of a status word and the arrival of the next acknowledge overlap in arbitrary cycles. Every outcome and every consumed-word count is judged against a bench model of the pass loop.

// File: rtl/nps_pkg.sv
package nps_pkg;

  typedef enum logic [1:0] {
    RES_NONE = 2'b00,
    RES_OK   = 2'b01,
    RES_ERR  = 2'b10,
    RES_TMO  = 2'b11
  } nps_res_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT_HI,
    S_WAIT_LO,
    S_ITER,
    S_RD_A,
    S_RD_B,
    S_RD_C,
    S_RD_D
  } nps_state_e;

endpackage

// File: rtl/nps_sync.sv
module nps_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= chain_d;
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/nps_down_counter.sv
module nps_down_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             dec_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign zero_o = (cnt_q == '0);
  assign cnt_en = load_i | (dec_i & ~zero_o);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                cnt_d = val_i;
    else if (dec_i && !zero_o) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R7: an exhausted budget never wraps back to a large value
  a_r7_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);

  // R11: a load of a non-zero value is seen as non-zero budget
  a_r11_load_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && (val_i != '0)) |=> !zero_o);

endmodule

// File: rtl/nps_pair_eval.sv
module nps_pair_eval #(
  parameter int DATA_W  = 16,
  parameter int TOG_BIT = 6,
  parameter int ERR_BIT = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              toggled_o,
  output logic              err_flag_o
);

  logic tog_q;
  logic err_q;
  logic unused_bits;

  assign unused_bits = ^data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q <= 1'b0;
      err_q <= 1'b0;
    end else if (cap_i) begin
      tog_q <= data_i[TOG_BIT];
      err_q <= data_i[ERR_BIT];
    end
  end

  assign toggled_o  = tog_q ^ data_i[TOG_BIT];
  assign err_flag_o = err_q;

endmodule

// File: rtl/nor_status_poller.sv
module nor_status_poller #(
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 16,
  parameter int TOG_BIT = 6,
  parameter int ERR_BIT = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  limit_i,
  input  logic              rdy_busy_i,
  output logic              rd_req_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              done_o,
  output logic [1:0]        result_o
);

  import nps_pkg::*;

  nps_state_e       state_q, state_d;
  nps_res_e         res_q, res_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] limit_q;
  logic             limit_en;
  logic             rb_s;
  logic             cnt_load, cnt_dec, cnt_zero;
  logic [CNT_W-1:0] cnt_val;
  logic             cap;
  logic             toggled, err_flag;

  nps_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (rdy_busy_i),
    .sync_o  (rb_s)
  );

  nps_down_counter #(.CNT_W(CNT_W)) u_budget (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load),
    .val_i  (cnt_val),
    .dec_i  (cnt_dec),
    .zero_o (cnt_zero)
  );

  nps_pair_eval #(.DATA_W(DATA_W), .TOG_BIT(TOG_BIT), .ERR_BIT(ERR_BIT)) u_pair (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (cap),
    .data_i     (rd_data_i),
    .toggled_o  (toggled),
    .err_flag_o (err_flag)
  );

  assign cnt_val = (state_q == S_IDLE) ? limit_i : limit_q;

  always_comb begin
    state_d  = state_q;
    res_d    = res_q;
    done_d   = 1'b0;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    cap      = 1'b0;
    limit_en = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          limit_en = 1'b1;
          cnt_load = 1'b1;
          state_d  = S_WAIT_HI;
        end
      end
      S_WAIT_HI: begin
        if (!rb_s || cnt_zero) begin
          cnt_load = 1'b1;
          state_d  = S_WAIT_LO;
        end else begin
          cnt_dec = 1'b1;
        end
      end
      S_WAIT_LO: begin
        if (rb_s || cnt_zero) begin
          cnt_load = 1'b1;
          state_d  = S_ITER;
        end else begin
          cnt_dec = 1'b1;
        end
      end
      S_ITER: begin
        if (cnt_zero) begin
          res_d   = RES_TMO;
          done_d  = 1'b1;
          state_d = S_IDLE;
        end else begin
          cnt_dec = 1'b1;
          state_d = S_RD_A;
        end
      end
      S_RD_A: begin
        if (rd_ack_i) begin
          cap     = 1'b1;
          state_d = S_RD_B;
        end
      end
      S_RD_B: begin
        if (rd_ack_i) begin
          if (!toggled) begin
            res_d   = RES_OK;
            done_d  = 1'b1;
            state_d = S_IDLE;
          end else begin
            state_d = S_RD_C;
          end
        end
      end
      S_RD_C: begin
        if (rd_ack_i) begin
          cap     = 1'b1;
          state_d = S_RD_D;
        end
      end
      S_RD_D: begin
        if (rd_ack_i) begin
          if (!toggled) begin
            res_d   = RES_OK;
            done_d  = 1'b1;
            state_d = S_IDLE;
          end else if (err_flag) begin
            res_d   = RES_ERR;
            done_d  = 1'b1;
            state_d = S_IDLE;
          end else begin
            state_d = S_ITER;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      res_q   <= RES_NONE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       limit_q <= '0;
    else if (limit_en) limit_q <= limit_i;
  end

  assign rd_req_o = (state_q == S_RD_A) || (state_q == S_RD_B) ||
                    (state_q == S_RD_C) || (state_q == S_RD_D);
  assign done_o   = done_q;
  assign result_o = res_q;

  // R9: the strobe lasts one cycle
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9: the code only moves together with the strobe
  a_r9_result_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  // R8: a pending request is not withdrawn
  a_r8_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i) |=> rd_req_o);

  // R4: success always follows an acknowledged read
  a_r4_ok_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (result_o == RES_OK)) |-> $past(rd_ack_i));

  // R6: error only comes out of the confirming pair
  a_r6_err_from_second_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (result_o == RES_ERR)) |-> ($past(state_q) == S_RD_D));

  // R1: done never carries an empty code
  a_r1_done_has_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (result_o != RES_NONE));

endmodule

// File: tb/tb_nor_status_poller.sv
module tb_nor_status_poller;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 32;
  localparam int DATA_W     = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              start_i;
  logic [CNT_W-1:0]  limit_i;
  logic              rdy_busy_i;
  logic              rd_req_o;
  logic              rd_ack_i;
  logic [DATA_W-1:0] rd_data_i;
  logic              done_o;
  logic [1:0]        result_o;

  int n_chk = 0;
  int n_bad = 0;
  int total_cyc = 0;
  logic [15:0] scr [0:255];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  nor_status_poller #(.CNT_W(CNT_W), .DATA_W(DATA_W)) dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .limit_i    (limit_i),
    .rdy_busy_i (rdy_busy_i),
    .rd_req_o   (rd_req_o),
    .rd_ack_i   (rd_ack_i),
    .rd_data_i  (rd_data_i),
    .done_o     (done_o),
    .result_o   (result_o)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      total_cyc++;
      if (total_cyc > 190000) begin
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
      end
    end
  end

  // status word i: bit 6 toggles until read k, bit 5 set from read e
  task automatic fill(input int k, input int e);
    for (int i = 0; i < 256; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      w[6] = 1'((i < k) ? i : k);
      w[5] = (i >= e);
      scr[i] = w;
    end
  endtask

  function automatic void model(input logic [31:0] lim, output logic [1:0] res,
                                output int nrd);
    longint t;
    int p;
    t = lim;
    p = 0;
    res = 2'b11;
    while (t != 0) begin
      t--;
      if (scr[p][6] == scr[p+1][6]) begin res = 2'b01; p += 2; break; end
      if (scr[p+2][6] == scr[p+3][6]) begin res = 2'b01; p += 4; break; end
      if (scr[p+2][5]) begin res = 2'b10; p += 4; break; end
      p += 4;
    end
    nrd = p;
  endfunction

  function automatic string tag_of(input logic [1:0] res, input int nrd);
    if (res == 2'b01 && nrd % 4 == 2) return "R4";
    if (res == 2'b01) return "R5";
    if (res == 2'b10) return "R6";
    return "R7";
  endfunction

  task automatic run_op(input logic [31:0] lim, input int low_at, input int high_at,
                        input int restart_at, output logic [1:0] res,
                        output int nrd, output int first_req, output int ndone);
    int idx, cyc, done_cyc;
    bit fin;
    @(negedge clk_i);
    start_i = 1'b1;
    limit_i = lim;
    idx = 0; cyc = 0; done_cyc = -1; ndone = 0; first_req = -1; fin = 0;
    res = 2'b00; nrd = 0;
    while (!fin) begin
      @(negedge clk_i);
      cyc++;
      start_i = (cyc == restart_at);
      limit_i = '0;
      if (rd_ack_i) idx++;
      rdy_busy_i = !(cyc >= low_at && cyc < high_at);
      if (done_o) begin
        ndone++;
        if (done_cyc < 0) begin
          done_cyc = cyc;
          res = result_o;
          nrd = idx;
        end
      end
      if (done_cyc > 0 && cyc == done_cyc + 1) chk("R9 done width", done_o, 0);
      if (done_cyc > 0 && cyc == done_cyc + 3) begin
        chk("R9 result held", result_o, res);
        fin = 1;
      end
      if (rd_req_o && first_req < 0) first_req = cyc;
      rd_ack_i  = rd_req_o && ($urandom % 4 != 0);
      rd_data_i = scr[idx[7:0]];
      if (cyc > 6000) begin
        n_bad++;
        $display("FAIL watchdog operation hung");
        fin = 1;
      end
    end
    rd_ack_i   = 1'b0;
    rdy_busy_i = 1'b1;
    start_i    = 1'b0;
  endtask

  task automatic check_op(input logic [31:0] lim, input int low_at, input int high_at);
    logic [1:0] res, eres;
    int nrd, enrd, fr, nd;
    model(lim, eres, enrd);
    run_op(lim, low_at, high_at, 0, res, nrd, fr, nd);
    chk(tag_of(eres, enrd), res, eres);
    chk("R8 words consumed", nrd, enrd);
  endtask

  initial begin
    logic [1:0] res, eres;
    int nrd, enrd, fr, nd;
    void'($urandom(32'h1F2E3D4C));
    rst_ni = 1'b0; start_i = 1'b0; limit_i = '0; rdy_busy_i = 1'b1;
    rd_ack_i = 1'b0; rd_data_i = '0;
    repeat (3) @(negedge clk_i);
    chk("R1 done in reset", done_o, 0);
    chk("R1 result in reset", result_o, 0);
    chk("R1 req in reset", rd_req_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 done after reset", done_o, 0);
    chk("R1 result after reset", result_o, 0);
    chk("R1 req after reset", rd_req_o, 0);

    // R2: line never drops, first wait runs out its budget
    fill(0, 1000);
    run_op(20, 100000, 100000, 0, res, nrd, fr, nd);
    chk("R2 no early read", (fr >= 20), 1);
    chk("R2 reads begin", (fr <= 32), 1);
    chk("R4 success first pair", res, 2'b01);

    // R3: line drops and never rises, second wait runs out
    fill(0, 1000);
    run_op(25, 2, 100000, 0, res, nrd, fr, nd);
    chk("R3 no early read", (fr >= 25), 1);
    chk("R3 reads begin", (fr <= 45), 1);

    // R3: line low until cycle 60 with a large budget
    fill(0, 1000);
    run_op(1000, 2, 60, 0, res, nrd, fr, nd);
    chk("R3 waits for ready", (fr >= 60), 1);
    chk("R3 reads after ready", (fr <= 70), 1);

    // R7: zero budget
    fill(0, 1000);
    run_op(0, 2, 6, 0, res, nrd, fr, nd);
    chk("R7 zero budget result", res, 2'b11);
    chk("R7 zero budget reads", nrd, 0);

    // R6: toggling with bit 5 set
    fill(1000, 0);
    run_op(5, 2, 6, 0, res, nrd, fr, nd);
    chk("R6 error result", res, 2'b10);
    chk("R6 error reads", nrd, 4);

    // R7: toggling, no error flag
    fill(1000, 1000);
    run_op(3, 2, 6, 0, res, nrd, fr, nd);
    chk("R7 timeout result", res, 2'b11);
    chk("R7 timeout reads", nrd, 12);

    // R5: confirming pair succeeds on the last unit of budget
    fill(2, 1000);
    run_op(1, 2, 6, 0, res, nrd, fr, nd);
    chk("R5 last budget success", res, 2'b01);
    chk("R5 last budget reads", nrd, 4);

    // R11: wide budget not truncated
    fill(0, 1000);
    run_op(32'h4000_0000, 2, 6, 0, res, nrd, fr, nd);
    chk("R11 wide budget", res, 2'b01);

    // R10: second start mid-operation ignored
    fill(6, 1000);
    model(10, eres, enrd);
    run_op(10, 2, 12, 5, res, nrd, fr, nd);
    chk("R10 single done", nd, 1);
    chk("R10 outcome unchanged", res, eres);

    for (int n = 0; n < 60; n++) begin
      int lo;
      fill(int'($urandom % 40), int'($urandom % 70));
      lo = 1 + int'($urandom % 4);
      check_op(32'($urandom % 31), lo, lo + int'($urandom % 30));
    end

    summary();
    $finish;
  end

endmodule